// File: doc/BRIEF.md
# Compare Timer with Selectable Tick Source

This block is an up-counting timer that sits on a simple single-cycle register bus. Software picks one of three tick sources: the bus-clock tick, the peripheral-clock tick, or an oscillator tick. The oscillator tick passes through its own small divider first. A main divider then scales the selected tick before it reaches the counter. The counter value can be read at any time. Software schedules an event by adding a delta to the current count and writing the sum into the compare register.

When the counter reaches the compare value, a sticky match flag is set. Software clears it by writing one to it. A level interrupt line is the match flag gated by an interrupt-enable bit. In free-running mode the counter runs past the match and wraps at its full width. In restart mode it returns to zero on the tick after the match. Writing zero to the control and divider registers stops the timer and clears its counts. An input that signals a low-power wait state stalls counting unless the control register allows counting during that state.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: The registers sit at these byte offsets:
  - 0x00: control. Bit 0 = run, bit 3 = count-in-wait, bits 8:6 = source code, bit 9 = free-run, bit 10 = oscillator-path enable.
  - 0x04: dividers. Bits PRE_W-1:0 = main divide, bits 12+OPRE_W-1:12 = oscillator divide.
  - 0x08: status. Bit 0 = match flag.
  - 0x0C: interrupt enable. Bit 0.
  - 0x10: compare.
  - 0x24: counter, read-only.

  Unstored bits read 0. Unmapped offsets read 0. Writes to 0x24 are ignored.
- R3: Source code 1 counts bus ticks, 2 counts peripheral ticks and 5 counts the oscillator path. Any other code produces no counts.
- R4: The main divider passes one tick per (main divide + 1) selected ticks.
- R5: With source code 5, oscillator ticks are first divided by (oscillator divide + 1). This happens only while the oscillator-path enable bit is 1; with that bit at 0, source 5 produces no counts.
- R6: In free-run mode the counter keeps incrementing past a match and wraps modulo 2^CNT_W.
- R7: With free-run clear, the counter goes to 0 on the first count tick after it holds the compare value.
- R8: The match flag is set on the count tick that brings the counter to the compare value. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: `irq` is high exactly while both the match flag and the interrupt-enable bit are 1, and it stays high until one of them is cleared.
- R10: While the run bit is 0, the counter and both divider counts are held at 0. The match flag keeps its value.
- R11: While `sleep_i` is high and count-in-wait is 0, counting stalls with the counter held. With count-in-wait set to 1, counting continues during `sleep_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from offset |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_per | input | 1 | Peripheral-clock tick enable |
| tick_osc | input | 1 | Oscillator tick enable |
| sleep_i | input | 1 | Low-power wait state indication |
| irq | output | 1 | Level compare interrupt |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit main divider and a 4-bit oscillator divider. The narrow counter makes the modulo-2^CNT_W wrap in free-run mode reachable in a few hundred ticks. The small dividers let every division ratio, including the divide-by-8 oscillator setting, be counted out tick by tick. The write masks to narrow fields are also checked by reading back all-ones writes.

// File: rtl/cmp_tmr_pkg.sv
package cmp_tmr_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DIV  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_CMP  = 8'h10;
    localparam logic [7:0] OFS_CNT  = 8'h24;

    localparam int BIT_RUN  = 0;
    localparam int BIT_WAIT = 3;
    localparam int BIT_SRC  = 6;
    localparam int BIT_FREE = 9;
    localparam int BIT_OSC  = 10;
    localparam int BIT_ODIV = 12;

    localparam logic [2:0] SRC_BUS = 3'd1;
    localparam logic [2:0] SRC_PER = 3'd2;
    localparam logic [2:0] SRC_OSC = 3'd5;

    typedef struct packed {
        logic       run;
        logic       wait_run;
        logic [2:0] src;
        logic       free;
        logic       osc_en;
    } ctrl_t;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import cmp_tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int OPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              flag,
    input  logic [CNT_W-1:0]  cnt,
    output logic [31:0]       rdata,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  main_div,
    output logic [OPRE_W-1:0] osc_div,
    output logic              ien,
    output logic [CNT_W-1:0]  cmp,
    output logic              clr_flag
);
    typedef struct packed {
        ctrl_t              ctrl;
        logic [PRE_W-1:0]   mdiv;
        logic [OPRE_W-1:0]  odiv;
        logic               ien;
        logic [CNT_W-1:0]   cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_en;

    assign wr_en = sel & wr;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                OFS_CTRL: begin
                    r_d.ctrl.run      = wdata[BIT_RUN];
                    r_d.ctrl.wait_run = wdata[BIT_WAIT];
                    r_d.ctrl.src      = wdata[BIT_SRC +: 3];
                    r_d.ctrl.free     = wdata[BIT_FREE];
                    r_d.ctrl.osc_en   = wdata[BIT_OSC];
                end
                OFS_DIV: begin
                    r_d.mdiv = wdata[PRE_W-1:0];
                    r_d.odiv = wdata[BIT_ODIV +: OPRE_W];
                end
                OFS_IEN: r_d.ien = wdata[0];
                OFS_CMP: r_d.cmp = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[BIT_RUN]      = r_q.ctrl.run;
                rdata[BIT_WAIT]     = r_q.ctrl.wait_run;
                rdata[BIT_SRC +: 3] = r_q.ctrl.src;
                rdata[BIT_FREE]     = r_q.ctrl.free;
                rdata[BIT_OSC]      = r_q.ctrl.osc_en;
            end
            OFS_DIV: begin
                rdata[PRE_W-1:0]           = r_q.mdiv;
                rdata[BIT_ODIV +: OPRE_W]  = r_q.odiv;
            end
            OFS_STAT: rdata[0]         = flag;
            OFS_IEN:  rdata[0]         = r_q.ien;
            OFS_CMP:  rdata[CNT_W-1:0] = r_q.cmp;
            OFS_CNT:  rdata[CNT_W-1:0] = cnt;
            default: ;
        endcase
    end

    assign ctrl     = r_q.ctrl;
    assign main_div = r_q.mdiv;
    assign osc_div  = r_q.odiv;
    assign ien      = r_q.ien;
    assign cmp      = r_q.cmp;
    assign clr_flag = wr_en && (addr == OFS_STAT) && wdata[0];

    // R2: a write to the compare offset lands in the compare register
    p_cmp_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CMP) |=> (cmp == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import cmp_tmr_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int OPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [PRE_W-1:0]  main_div,
    input  logic [OPRE_W-1:0] osc_div,
    input  logic              tick_bus,
    input  logic              tick_per,
    input  logic              tick_osc,
    input  logic              sleep_i,
    output logic              cnt_tick
);
    typedef struct packed {
        logic [OPRE_W-1:0] ocnt;
        logic [PRE_W-1:0]  pcnt;
    } div_t;

    div_t s_d, s_q;
    logic run_ok, osc_evt, osc_out, src_raw, src_tick, pre_out;

    always_comb begin
        s_d      = s_q;
        run_ok   = ctrl.run & (~sleep_i | ctrl.wait_run);
        osc_evt  = tick_osc & ctrl.osc_en & run_ok;
        osc_out  = osc_evt & (s_q.ocnt >= osc_div);
        case (ctrl.src)
            SRC_BUS: src_raw = tick_bus;
            SRC_PER: src_raw = tick_per;
            SRC_OSC: src_raw = osc_out;
            default: src_raw = 1'b0;
        endcase
        src_tick = src_raw & run_ok;
        pre_out  = src_tick & (s_q.pcnt >= main_div);

        if (osc_evt)
            s_d.ocnt = osc_out ? '0 : s_q.ocnt + 1'b1;
        if (src_tick)
            s_d.pcnt = pre_out ? '0 : s_q.pcnt + 1'b1;
        if (!ctrl.run)
            s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_tick = pre_out;

    // R5: oscillator source with its path disabled never yields a count
    p_osc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src == SRC_OSC && !ctrl.osc_en) |-> !cnt_tick);
    // R11: stalled in wait state, no count tick leaves the divider
    p_wait_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !ctrl.wait_run) |-> !cnt_tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             free,
    input  logic [CNT_W-1:0] cmp,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cst_t;

    cst_t c_d, c_q;
    logic [CNT_W-1:0] nxt_val;

    always_comb begin
        c_d     = c_q;
        nxt_val = (!free && c_q.cnt == cmp) ? '0 : c_q.cnt + 1'b1;
        if (clr_flag)
            c_d.flag = 1'b0;
        if (!run) begin
            c_d.cnt = '0;
        end else if (tick) begin
            c_d.cnt = nxt_val;
            if (nxt_val == cmp)
                c_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt  = c_q.cnt;
    assign flag = c_q.flag;

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(c_q.cnt));
    p_free_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && free) |=> (c_q.cnt == $past(c_q.cnt) + 1'b1));
    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !free && c_q.cnt == cmp) |=> (c_q.cnt == '0));
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.flag && !clr_flag) |=> c_q.flag);
    p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (c_q.cnt == '0));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int OPRE_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_bus,
    input  logic        tick_per,
    input  logic        tick_osc,
    input  logic        sleep_i,
    output logic        irq
);
    ctrl_t             ctrl;
    logic [PRE_W-1:0]  main_div;
    logic [OPRE_W-1:0] osc_div;
    logic              ien, clr_flag, flag, cnt_tick;
    logic [CNT_W-1:0]  cmp, cnt;

    tmr_regfile #(.CNT_W(CNT_W), .PRE_W(PRE_W), .OPRE_W(OPRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .flag(flag), .cnt(cnt), .rdata(bus_rdata),
        .ctrl(ctrl), .main_div(main_div), .osc_div(osc_div), .ien(ien),
        .cmp(cmp), .clr_flag(clr_flag)
    );

    tmr_tick_gen #(.PRE_W(PRE_W), .OPRE_W(OPRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .main_div(main_div),
        .osc_div(osc_div), .tick_bus(tick_bus), .tick_per(tick_per),
        .tick_osc(tick_osc), .sleep_i(sleep_i), .cnt_tick(cnt_tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(cnt_tick),
        .free(ctrl.free), .cmp(cmp), .clr_flag(clr_flag), .cnt(cnt),
        .flag(flag)
    );

    assign irq = flag & ien;

    // R9: the interrupt stays up until its flag is cleared or it is disabled
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_sel && bus_wr && (bus_addr == OFS_STAT || bus_addr == OFS_IEN)))
        |=> irq);
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0, sleep_i = 1'b0;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cmp_timer #(.CNT_W(8), .PRE_W(4), .OPRE_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_bus(tick_bus), .tick_per(tick_per), .tick_osc(tick_osc),
        .sleep_i(sleep_i), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(input bit b, input bit p, input bit o, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_bus = b; tick_per = p; tick_osc = o;
            @(negedge clk);
            tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
        end
    endtask

    task automatic clean();
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h0C, 0); wr(8'h08, 1);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 8'h00, 0); rd_chk("R1 div", 8'h04, 0);
        rd_chk("R1 stat", 8'h08, 0); rd_chk("R1 ien", 8'h0C, 0);
        rd_chk("R1 cmp", 8'h10, 0);  rd_chk("R1 cnt", 8'h24, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regs();
        wr(8'h00, 32'h0000_0689); rd_chk("R2 ctrl readback", 8'h00, 32'h689);
        wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2 ctrl mask", 8'h00, 32'h7C9);
        wr(8'h00, 0);
        wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 div mask", 8'h04, 32'hF00F);
        wr(8'h0C, 32'hFFFF_FFFF); rd_chk("R2 ien mask", 8'h0C, 1);
        wr(8'h10, 32'h0000_01FF); rd_chk("R2 cmp mask", 8'h10, 32'hFF);
        rd_chk("R2 unmapped", 8'h14, 0);
        wr(8'h24, 32'h55);        rd_chk("R2 cnt write ignored", 8'h24, 0);
        clean();
    endtask

    task automatic t_src();
        wr(8'h10, 32'hFF);
        wr(8'h00, 32'h241);                    // bus source, free-run
        pulse(0, 1, 1, 3); rd_chk("R3 bus ignores others", 8'h24, 0);
        pulse(1, 0, 0, 3); rd_chk("R3 bus counts", 8'h24, 3);
        wr(8'h00, 0);      rd_chk("R10 stop clears", 8'h24, 0);
        wr(8'h00, 32'h281);                    // peripheral source
        pulse(1, 0, 0, 2); rd_chk("R3 per ignores bus", 8'h24, 0);
        pulse(0, 1, 0, 4); rd_chk("R3 per counts", 8'h24, 4);
        wr(8'h00, 32'h2C1);                    // code 3: no source
        pulse(1, 1, 1, 3); rd_chk("R3 unused code", 8'h24, 4);
        clean();
    endtask

    task automatic t_prescale();
        wr(8'h10, 32'hFF); wr(8'h04, 2); wr(8'h00, 32'h281);
        pulse(0, 1, 0, 8); rd_chk("R4 div3 after 8", 8'h24, 2);
        pulse(0, 1, 0, 1); rd_chk("R4 div3 after 9", 8'h24, 3);
        clean();
    endtask

    task automatic t_osc();
        wr(8'h10, 32'hFF); wr(8'h04, 32'h7001);
        wr(8'h00, 32'h341);                    // source 5, path disabled
        pulse(0, 0, 1, 16); rd_chk("R5 path off", 8'h24, 0);
        wr(8'h00, 0); wr(8'h00, 32'h741);
        pulse(0, 0, 1, 16); rd_chk("R5 div8 then div2 (16)", 8'h24, 1);
        pulse(0, 0, 1, 32); rd_chk("R5 div8 then div2 (48)", 8'h24, 3);
        clean();
    endtask

    task automatic t_free();
        wr(8'h10, 5); wr(8'h00, 32'h281);
        pulse(0, 1, 0, 5); rd_chk("R8 match sets flag", 8'h08, 1);
        chk("R9 irq off while disabled", {31'b0, irq}, 0);
        pulse(0, 1, 0, 1); rd_chk("R6 passes compare", 8'h24, 6);
        wr(8'h08, 0);      rd_chk("R8 write 0 keeps flag", 8'h08, 1);
        wr(8'h08, 1);      rd_chk("R8 write 1 clears", 8'h08, 0);
        pulse(0, 1, 0, 249); rd_chk("R6 top value", 8'h24, 255);
        pulse(0, 1, 0, 1);   rd_chk("R6 wrap", 8'h24, 0);
        rd_chk("R8 no flag off compare", 8'h08, 0);
        pulse(0, 1, 0, 5);   rd_chk("R8 rematch after wrap", 8'h08, 1);
        clean();
    endtask

    task automatic t_restart();
        wr(8'h10, 3); wr(8'h00, 32'h081);
        pulse(0, 1, 0, 3); rd_chk("R7 reaches compare", 8'h24, 3);
        rd_chk("R8 flag in restart", 8'h08, 1);
        pulse(0, 1, 0, 1); rd_chk("R7 back to zero", 8'h24, 0);
        pulse(0, 1, 0, 2); rd_chk("R7 counts again", 8'h24, 2);
        clean();
    endtask

    task automatic t_irq();
        wr(8'h10, 2); wr(8'h0C, 1); wr(8'h00, 32'h281);
        pulse(0, 1, 0, 1); chk("R9 irq low before match", {31'b0, irq}, 0);
        pulse(0, 1, 0, 1); chk("R9 irq on match", {31'b0, irq}, 1);
        pulse(0, 1, 0, 3); chk("R9 irq held", {31'b0, irq}, 1);
        wr(8'h0C, 0);      chk("R9 irq masked", {31'b0, irq}, 0);
        rd_chk("R9 flag kept when masked", 8'h08, 1);
        wr(8'h0C, 1);      chk("R9 irq unmasked", {31'b0, irq}, 1);
        wr(8'h08, 1);      chk("R9 irq cleared", {31'b0, irq}, 0);
        clean();
        // set and clear in the same cycle: set wins
        wr(8'h10, 1); wr(8'h00, 32'h281);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 1; tick_per = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_per = 1'b0;
        rd_chk("R8 set beats clear", 8'h08, 1);
        wr(8'h00, 0);
        rd_chk("R10 flag kept on stop", 8'h08, 1);
        clean();
    endtask

    task automatic t_disable();
        wr(8'h10, 32'hFF); wr(8'h04, 3); wr(8'h00, 32'h281);
        pulse(0, 1, 0, 2);
        wr(8'h00, 0); wr(8'h00, 32'h281);
        pulse(0, 1, 0, 3); rd_chk("R10 divider count cleared", 8'h24, 0);
        pulse(0, 1, 0, 1); rd_chk("R10 fresh division", 8'h24, 1);
        clean();
    endtask

    task automatic t_wait();
        wr(8'h10, 32'hFF); wr(8'h00, 32'h281);
        sleep_i = 1'b1;
        pulse(0, 1, 0, 3); rd_chk("R11 stalled in wait", 8'h24, 0);
        wr(8'h00, 32'h289);
        pulse(0, 1, 0, 3); rd_chk("R11 counts in wait", 8'h24, 3);
        sleep_i = 1'b0;
        wr(8'h00, 32'h281);
        pulse(0, 1, 0, 1); rd_chk("R11 counts awake", 8'h24, 4);
        clean();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_src();
        t_prescale();
        t_osc();
        t_free();
        t_restart();
        t_irq();
        t_disable();
        t_wait();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule